// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block connects an on-chip requester to an external asynchronous static RAM. The RAM has 19 address bits and an 8-bit data path. The requester presents an address, write data and a write flag under a valid/ready handshake. The controller then drives the RAM pins as a fixed, cycle-counted sequence: two chip selects (one active low, one active high), an active-low output enable, an active-low write strobe, the data bus and its tri-state enable. Read data comes back with a one-cycle response pulse.

Every timing rule of the RAM is a parameter given in picoseconds. Each rule is turned into a cycle count by rounding up against the clock period, and a zero result is raised to one cycle. Some RAMs sense data only when the enable rises or an address bit toggles. Skew between those two events can start a second internal read and corrupt the data. To prevent this, the address is always driven and left to settle before any chip select moves. The address never changes in a cycle in which a chip select or strobe changes.

All pin outputs come straight from flops and are decoded from the next phase, so they do not glitch. The read data bus is sampled by a flop.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is active and after it is released, the RAM is deselected (active-low select high, active-high select low), output enable and write strobe are high, the bus enable is low and ready is high.
- R2: The address is driven at least N_SKEW = ceil(T_SKEW/T_CLK) cycles before the selects turn on. The address holds the same value in every cycle in which the RAM is selected, and in the first cycle after the selects turn off.
- R3: A read holds both selects active, output enable low and write strobe high. The bus is sampled after N_ACC + 1 selected cycles, where N_ACC = ceil(T_ACC/T_CLK). With a 5 ns clock the response appears N_SKEW + N_ACC + 2 falling edges after the accepting rising edge, and it carries the byte last written to that address.
- R4: A write lowers the write strobe for exactly max(ceil(T_WP/T_CLK), ceil(T_DS/T_CLK)) cycles. The selects turn on at least one cycle before the strobe falls and stay on in the cycle after it rises.
- R5: The bus enable is high during the whole strobe-low window and in the cycle after the strobe rises. The driven byte is constant over that span and equals the write data captured at acceptance.
- R6: The bus enable is never high while output enable is low. Output enable is high in the cycle in which the strobe falls.
- R7: Between two strobe-low pulses the strobe stays high for at least ceil(T_WHWL/T_CLK) cycles.
- R8: A request is accepted only on a rising edge where valid and ready are both high. Ready stays low from acceptance until the sequence ends, so request fields that change while busy do not affect the access in progress.
- R9: Each read yields exactly one one-cycle response pulse, and a write yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write byte |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | DW | Read byte |
| sram_addr_o | output | AW | RAM address pins |
| sram_ce1_no | output | 1 | RAM select, active low |
| sram_ce2_o | output | 1 | RAM select, active high |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write strobe, active low |
| sram_dq_o | output | DW | Byte driven onto the bus |
| sram_dq_oe_o | output | 1 | Bus tri-state enable, 1 = controller drives |
| sram_dq_i | input | DW | Byte read from the bus |

## Verification
The bench models the RAM. Its output is garbage until the access time has run out since select, so a controller that samples one cycle early returns the wrong byte. The sweep runs walking-one addresses plus the all-zero and all-one addresses. A controller that lets the address move while selected, or in the same edge as the select, is caught by the settle-and-hold check. A controller that shortens the strobe, drops the bus enable at the strobe's rising edge, or drives the bus while output enable is low is caught by the strobe monitors. A controller that accepts work while busy is caught by changing the request fields and holding valid high in mid-access, then reading both addresses back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_RACC   = 3'd2,
    PH_RCAPT  = 3'd3,
    PH_WCE    = 3'd4,
    PH_WPULSE = 3'd5,
    PH_WHOLD  = 3'd6,
    PH_RECOV  = 3'd7
  } phase_e;

  // internal active-high pin controls
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic dq_en;
  } pin_ctl_t;

  function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned rem_or_one(input int unsigned need, input int unsigned used);
    return (need > used) ? need - used : 1;
  endfunction

  function automatic pin_ctl_t phase_ctl(input phase_e ph);
    pin_ctl_t c;
    c = '0;
    unique case (ph)
      PH_RACC, PH_RCAPT: begin c.sel = 1'b1; c.oe = 1'b1; end
      PH_WCE:            c.sel = 1'b1;
      PH_WPULSE:         begin c.sel = 1'b1; c.we = 1'b1; c.dq_en = 1'b1; end
      PH_WHOLD:          begin c.sel = 1'b1; c.dq_en = 1'b1; end
      default:           c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_phase_fsm.sv
`timescale 1ns/1ps
module sram_phase_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_SKEW  = 1,
  parameter int unsigned N_ACC   = 3,
  parameter int unsigned N_WCE   = 1,
  parameter int unsigned N_WP    = 3,
  parameter int unsigned N_WH    = 1,
  parameter int unsigned N_REC_R = 1,
  parameter int unsigned N_REC_W = 1,
  parameter int unsigned CW      = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          expired_i,
  output phase_e        phase_o,
  output phase_e        phase_next_o,
  output logic          accept_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          capture_o
);
  phase_e state_q, state_d;
  logic   wr_q, wr_d;

  always_comb begin
    state_d    = state_q;
    wr_d       = wr_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      PH_IDLE: if (req_valid_i) begin
        state_d = PH_SETUP; wr_d = req_write_i;
        load_o = 1'b1; load_val_o = CW'(N_SKEW - 1);
      end
      PH_SETUP: if (expired_i) begin
        load_o = 1'b1;
        if (wr_q) begin state_d = PH_WCE;  load_val_o = CW'(N_WCE - 1); end
        else      begin state_d = PH_RACC; load_val_o = CW'(N_ACC - 1); end
      end
      PH_RACC: if (expired_i) begin
        state_d = PH_RCAPT; load_o = 1'b1; load_val_o = '0;
      end
      PH_RCAPT: if (expired_i) begin
        state_d = PH_RECOV; load_o = 1'b1; load_val_o = CW'(N_REC_R - 1);
      end
      PH_WCE: if (expired_i) begin
        state_d = PH_WPULSE; load_o = 1'b1; load_val_o = CW'(N_WP - 1);
      end
      PH_WPULSE: if (expired_i) begin
        state_d = PH_WHOLD; load_o = 1'b1; load_val_o = CW'(N_WH - 1);
      end
      PH_WHOLD: if (expired_i) begin
        state_d = PH_RECOV; load_o = 1'b1; load_val_o = CW'(N_REC_W - 1);
      end
      PH_RECOV: if (expired_i) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
    end
  end

  assign phase_o      = state_q;
  assign phase_next_o = state_d;
  assign accept_o     = (state_q == PH_IDLE) && req_valid_i;
  assign capture_o    = (state_q == PH_RCAPT) && expired_i;
endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  phase_e        phase_next_i,
  input  logic          capture_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic          ce1_no,
  output logic          ce2_o,
  output logic          oe_no,
  output logic          we_no,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  pin_ctl_t      ctl_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;

  // pins follow the next phase through one flop: glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= phase_ctl(phase_next_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o   = addr_q;
  assign ce1_no   = ~ctl_q.sel;
  assign ce2_o    = ctl_q.sel;
  assign oe_no    = ~ctl_q.oe;
  assign we_no    = ~ctl_q.we;
  assign dq_o     = wdata_q;
  assign dq_oe_o  = ctl_q.dq_en;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW         = 19,
  parameter int unsigned DW         = 8,
  parameter int unsigned CLK_PS     = 5000,
  parameter int unsigned T_SKEW_PS  = 4000,
  parameter int unsigned T_RC_PS    = 15000,
  parameter int unsigned T_ACC_PS   = 15000,
  parameter int unsigned T_AS_PS    = 1000,
  parameter int unsigned T_WP_PS    = 12000,
  parameter int unsigned T_DS_PS    = 7000,
  parameter int unsigned T_DH_PS    = 2000,
  parameter int unsigned T_AH_PS    = 2000,
  parameter int unsigned T_WHWL_PS  = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce1_no,
  output logic          sram_ce2_o,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int unsigned N_SKEW  = cyc_of(T_SKEW_PS, CLK_PS);
  localparam int unsigned N_ACC   = cyc_of(T_ACC_PS, CLK_PS);
  localparam int unsigned N_WCE   = cyc_of(T_AS_PS, CLK_PS);
  localparam int unsigned N_WP    = umax(cyc_of(T_WP_PS, CLK_PS), cyc_of(T_DS_PS, CLK_PS));
  localparam int unsigned N_WH    = umax(umax(cyc_of(T_AH_PS, CLK_PS), cyc_of(T_DH_PS, CLK_PS)),
                                         cyc_of(T_WHWL_PS, CLK_PS));
  localparam int unsigned N_RC    = cyc_of(T_RC_PS, CLK_PS);
  localparam int unsigned N_REC_R = rem_or_one(N_RC, N_ACC + 1);
  localparam int unsigned N_REC_W = rem_or_one(N_RC, N_WCE + N_WP + N_WH);
  localparam int unsigned N_MAX   = umax(umax(umax(N_SKEW, N_ACC), umax(N_WCE, N_WP)),
                                         umax(N_WH, umax(N_REC_R, N_REC_W)));
  localparam int unsigned CW      = $clog2(N_MAX + 1);

  phase_e        phase, phase_next;
  logic          accept, load, expired, capture;
  logic [CW-1:0] load_val;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  sram_phase_fsm #(
    .N_SKEW(N_SKEW), .N_ACC(N_ACC), .N_WCE(N_WCE), .N_WP(N_WP),
    .N_WH(N_WH), .N_REC_R(N_REC_R), .N_REC_W(N_REC_W), .CW(CW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .expired_i    (expired),
    .phase_o      (phase),
    .phase_next_o (phase_next),
    .accept_o     (accept),
    .load_o       (load),
    .load_val_o   (load_val),
    .capture_o    (capture)
  );

  sram_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .addr_i       (req_addr_i),
    .wdata_i      (req_wdata_i),
    .phase_next_i (phase_next),
    .capture_i    (capture),
    .dq_i         (sram_dq_i),
    .addr_o       (sram_addr_o),
    .ce1_no       (sram_ce1_no),
    .ce2_o        (sram_ce2_o),
    .oe_no        (sram_oe_no),
    .we_no        (sram_we_no),
    .dq_o         (sram_dq_o),
    .dq_oe_o      (sram_dq_oe_o),
    .rdata_o      (rsp_rdata_o),
    .rvalid_o     (rsp_valid_o)
  );

  assign req_ready_o = (phase == PH_IDLE);
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 19,
  parameter int unsigned DW        = 8,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_ACC_PS  = 15000,
  parameter int unsigned T_WP_PS   = 12000,
  parameter int unsigned T_DS_PS   = 7000,
  parameter int unsigned T_WHWL_PS = 5000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_ce1_no,
  input logic          sram_ce2_o,
  input logic          sram_oe_no,
  input logic          sram_we_no,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe_o
);
  localparam int unsigned C_ACC  = cyc_of(T_ACC_PS, CLK_PS);
  localparam int unsigned C_WP   = umax(cyc_of(T_WP_PS, CLK_PS), cyc_of(T_DS_PS, CLK_PS));
  localparam int unsigned C_WHWL = cyc_of(T_WHWL_PS, CLK_PS);

  logic        sel;
  int unsigned sel_cnt, lo_cnt, hi_cnt;

  assign sel = !sram_ce1_no && sram_ce2_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_cnt <= 0;
      lo_cnt  <= 0;
      hi_cnt  <= 1000;
    end else begin
      sel_cnt <= sel ? ((sel_cnt < 1000) ? sel_cnt + 1 : sel_cnt) : 0;
      lo_cnt  <= !sram_we_no ? ((lo_cnt < 1000) ? lo_cnt + 1 : lo_cnt) : 0;
      hi_cnt  <= sram_we_no ? ((hi_cnt < 1000) ? hi_cnt + 1 : hi_cnt) : 0;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_pins: assert (sram_ce1_no && !sram_ce2_o && sram_oe_no && sram_we_no
                               && !sram_dq_oe_o && req_ready_o);
    end
  end

  a_r2_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel || $past(sel)) |-> $stable(sram_addr_o));

  a_r3_read_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> sel && sram_we_no);

  a_r3_access_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> sel_cnt >= C_ACC + 1);

  a_r4_strobe_in_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sel && $past(sel));

  a_r4_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sel && lo_cnt >= C_WP);

  a_r5_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);

  a_r5_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no && $past(sram_oe_no));

  a_r7_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> hi_cnt >= C_WHWL);

  a_r8_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |-> !req_ready_o);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_PS(CLK_PS), .T_ACC_PS(T_ACC_PS),
  .T_WP_PS(T_WP_PS), .T_DS_PS(T_DS_PS), .T_WHWL_PS(T_WHWL_PS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce1_no  (sram_ce1_no),
  .sram_ce2_o   (sram_ce2_o),
  .sram_oe_no   (sram_oe_no),
  .sram_we_no   (sram_we_no),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int CLK_PS = 5000;
  localparam int NSWEEP = 21;
  localparam int EXP_SKEW = (4000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_ACC  = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_A     = (12000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_B     = (7000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_WP   = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int EXP_WHWL = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_RLAT = EXP_SKEW + EXP_ACC + 2;
  localparam real T_ACC_NS = 15.0;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          req_ready_o, rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic [AW-1:0] sram_addr_o;
  logic          sram_ce1_no, sram_ce2_o, sram_oe_no, sram_we_no, sram_dq_oe_o;
  logic [DW-1:0] sram_dq_o;
  logic [DW-1:0] dq_in = 8'h5A;

  int  n_tests = 0, n_fail = 0;
  bit  cur_wr = 1'b0;
  logic [7:0] mem [int];
  realtime t_sel = 0.0;

  always #2.5 clk = ~clk;

  sram_async_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .sram_addr_o(sram_addr_o), .sram_ce1_no(sram_ce1_no), .sram_ce2_o(sram_ce2_o),
    .sram_oe_no(sram_oe_no), .sram_we_no(sram_we_no),
    .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o), .sram_dq_i(dq_in)
  );

  wire sel = !sram_ce1_no && sram_ce2_o;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) ^ ((i * 3) << 4));
  endfunction

  function automatic logic [AW-1:0] sweep_addr(input int i);
    if (i == 0) return '0;
    if (i == NSWEEP - 1) return '1;
    return AW'(1) << (i - 1);
  endfunction

  function automatic logic [7:0] mem_rd(input logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  // RAM model: bus carries garbage until access time since select
  always @(posedge sel) t_sel = $realtime;
  always @(negedge clk) begin
    if (sel && !sram_oe_no && sram_we_no && ($realtime - t_sel >= T_ACC_NS))
      dq_in <= mem_rd(sram_addr_o);
    else
      dq_in <= 8'h5A;
  end

  // pin monitor
  logic          p_sel, p_we_n, p_oe_n;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dq;
  int            lo_cnt, hi_cnt;
  bit            addr_ok, dq_ok;

  always @(negedge clk) begin
    if (!rst_ni) begin
      p_sel = 1'b0; p_we_n = 1'b1; p_oe_n = 1'b1;
      p_addr = sram_addr_o; p_dq = sram_dq_o;
      lo_cnt = 0; hi_cnt = 1000; addr_ok = 1'b1; dq_ok = 1'b1;
    end else begin
      if (sel && !p_sel) begin
        chk(sram_addr_o == p_addr, "R2", "address settled before select", sram_addr_o, p_addr);
        chk(!req_ready_o, "R8", "ready low while selected", req_ready_o, 0);
        addr_ok = 1'b1;
      end
      if (sel && p_sel && sram_addr_o != p_addr) addr_ok = 1'b0;
      if (!sel && p_sel)
        chk(addr_ok && sram_addr_o == p_addr, "R2", "address held through select",
            sram_addr_o, p_addr);
      if (!sram_oe_no && p_oe_n)
        chk(sel && sram_we_no && !sram_dq_oe_o, "R3", "read pin state", {sel, sram_we_no, sram_dq_oe_o}, 3'b110);
      if (!sram_we_no && p_we_n) begin
        chk(p_sel && sel, "R4", "select before strobe", {p_sel, sel}, 2'b11);
        chk(sram_oe_no && sram_dq_oe_o, "R6", "output enable high at strobe", {sram_oe_no, sram_dq_oe_o}, 2'b11);
        chk(hi_cnt >= EXP_WHWL, "R7", "strobe high gap", hi_cnt, EXP_WHWL);
        lo_cnt = 0; dq_ok = 1'b1;
      end
      if (!sram_we_no) begin
        lo_cnt++;
        if (!p_we_n && sram_dq_o != p_dq) dq_ok = 1'b0;
        if (!sram_dq_oe_o) dq_ok = 1'b0;
        hi_cnt = 0;
      end else if (hi_cnt < 1000) hi_cnt++;
      if (sram_we_no && !p_we_n) begin
        chk(lo_cnt == EXP_WP, "R4", "strobe low cycles", lo_cnt, EXP_WP);
        chk(sel, "R4", "select held after strobe", sel, 1);
        chk(sram_dq_oe_o && sram_dq_o == p_dq && dq_ok, "R5", "data window", sram_dq_oe_o, 1);
        if (sel) mem[int'(sram_addr_o)] = sram_dq_o;
      end
      if (sram_dq_oe_o && !sram_oe_no)
        chk(1'b0, "R6", "bus driven with output enable low", 1, 0);
      if (rsp_valid_o) chk(!cur_wr, "R9", "response during write", 1, 0);
      p_sel = sel; p_we_n = sram_we_no; p_oe_n = sram_oe_no;
      p_addr = sram_addr_o; p_dq = sram_dq_o;
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    wait_ready();
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d; cur_wr = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    wait_ready();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] exp);
    int cyc;
    wait_ready();
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a; cur_wr = 1'b0;
    @(negedge clk);
    req_valid_i = 1'b0;
    cyc = 1;
    while (!rsp_valid_o && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == EXP_RLAT, "R3", "read latency", cyc, EXP_RLAT);
    chk(rsp_rdata_o == exp, "R3", "read data", rsp_rdata_o, exp);
    @(negedge clk);
    chk(!rsp_valid_o, "R9", "single response pulse", rsp_valid_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sram_ce1_no && !sram_ce2_o, "R1", "deselected in reset", {sram_ce1_no, sram_ce2_o}, 2'b10);
    chk(sram_oe_no && sram_we_no && !sram_dq_oe_o, "R1", "strobes idle in reset",
        {sram_oe_no, sram_we_no, sram_dq_oe_o}, 3'b110);
    chk(req_ready_o && !rsp_valid_o, "R1", "ready in reset", req_ready_o, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(sram_ce1_no && !sram_ce2_o && sram_we_no && sram_oe_no && req_ready_o, "R1",
        "idle after reset", {sram_ce1_no, sram_ce2_o, sram_we_no, sram_oe_no, req_ready_o}, 5'b10111);

    for (int i = 0; i < NSWEEP; i++) do_write(sweep_addr(i), pat(i));
    for (int i = NSWEEP - 1; i >= 0; i--) do_read(sweep_addr(i), pat(i));

    // overwrite same address back to back
    do_write(19'h12345, 8'hC3);
    do_write(19'h12345, 8'h3C);
    do_read(19'h12345, 8'h3C);

    // R8: fields change and valid stays high while busy
    wait_ready();
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 19'h0AAAA; req_wdata_i = 8'h71; cur_wr = 1'b1;
    @(negedge clk);
    req_addr_i = 19'h05555; req_wdata_i = 8'h8E;
    begin
      int busy = 0;
      while (!req_ready_o) begin
        busy++;
        @(negedge clk);
      end
      chk(busy >= EXP_SKEW + EXP_WP + 2, "R8", "ready held low for whole write", busy, EXP_SKEW + EXP_WP + 2);
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    wait_ready();
    do_read(19'h0AAAA, 8'h71);
    do_read(19'h05555, 8'h8E);
    // sweep data still intact
    do_read(sweep_addr(5), pat(5));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule